// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. It runs two direction predictors side by side. The first is a per-branch two-level predictor. A table of branch history patterns is indexed by PC bits, and the selected pattern then indexes a table of 2-bit saturating counters. The second is a history-indexed predictor. A single global shift register of resolved outcomes indexes its own table of 2-bit counters. A third table of 2-bit counters, indexed by PC bits, acts as a chooser. For each branch it decides which of the two component predictions becomes the final answer.

The predict port is purely combinational. The fetch stage presents a PC and, in the same cycle, receives the final direction and both component predictions. The component predictions are kept with the branch until it resolves. The update port then takes the PC, the actual outcome and the two saved component predictions. In one clock it trains both components, moves the chooser toward the component that was right, and shifts both history registers. Speculative history repair is not part of this block. The global history advances only on resolved updates.

Top module: `tbp_top`

## Requirements
- R1: After reset every direction counter and every chooser counter holds 1, and every history register holds 0. As a result, all three prediction outputs read 0 (not taken) for every PC.
- R2: The local component prediction is bit 1 of the local counter addressed by the history pattern. That pattern is the one stored in the history entry selected by PC bits [PC_LSB+LHT_AW-1:PC_LSB].
- R3: The global component prediction is bit 1 of the global counter addressed directly by the GH_W-bit global history register.
- R4: The final prediction equals the global component prediction when the chooser counter is 2 or 3, and the local component prediction when it is 0 or 1. The chooser counter is selected by PC bits [PC_LSB+CH_AW-1:PC_LSB]. All outputs respond combinationally to pred_pc_i.
- R5: Every counter saturates. An increment at 3 leaves 3, and a decrement at 0 leaves 0. Otherwise a taken or toward-global update adds 1, and any other update subtracts 1.
- R6: On each valid update, the local counter at the updated branch's current history and the global counter at the current global history both move toward upd_taken_i. This happens whichever component the chooser was selecting.
- R7: On a valid update the chooser entry changes only when upd_local_i differs from upd_global_i. It increments when upd_global_i equals upd_taken_i and decrements otherwise.
- R8: On a valid update, upd_taken_i is shifted into bit 0 of the global history and into bit 0 of the updated branch's history entry, and the oldest bit is dropped.
- R9: While upd_valid_i is 0, no counter and no history changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_pc_i | input | PC_W | PC of the branch being predicted |
| pred_taken_o | output | 1 | Final predicted direction |
| pred_local_o | output | 1 | Local component prediction |
| pred_global_o | output | 1 | Global component prediction |
| upd_valid_i | input | 1 | Resolved branch update strobe |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |
| upd_local_i | input | 1 | Local prediction made for this branch |
| upd_global_i | input | 1 | Global prediction made for this branch |

## Verification
Several properties are checked on every cycle: the shift of the global history, the shift of the per-branch history when the predicted and updated PCs coincide, the global history holding still when no update arrives, the chooser holding when the two components agreed, and the chooser's saturation at both ends. The bench uses a small configuration in which every PC can be swept after each step. It compares all three outputs against an arithmetic model of the tables. Only those sweeps show the counter training of both components, the selection by the chooser, the reset contents, the aliasing of PC bits outside the index fields, and the absence of any effect from update fields presented without the strobe.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_INIT = 2'd1;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_idx_i,
  output ctr_t          rd_ctr_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic          wr_up_i
);
  localparam int N = 1 << AW;

  ctr_t mem_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) mem_q[i] <= CTR_INIT;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= ctr_step(mem_q[wr_idx_i], wr_up_i);
    end
  end

  assign rd_ctr_o = mem_q[rd_idx_i];
endmodule

// File: rtl/tbp_local.sv
module tbp_local
  import tbp_pkg::*;
#(
  parameter int LHT_AW = 10,
  parameter int LH_W   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LHT_AW-1:0] pred_idx_i,
  output logic              pred_o,
  output logic [LH_W-1:0]   lhist_o,
  input  logic              upd_en_i,
  input  logic [LHT_AW-1:0] upd_idx_i,
  input  logic              upd_taken_i
);
  localparam int NH = 1 << LHT_AW;

  logic [LH_W-1:0] hist_q [NH];
  logic [LH_W-1:0] upd_hist;
  ctr_t            rd_ctr;

  assign lhist_o  = hist_q[pred_idx_i];
  assign upd_hist = hist_q[upd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NH; i++) hist_q[i] <= '0;
    end else if (upd_en_i) begin
      hist_q[upd_idx_i] <= {upd_hist[LH_W-2:0], upd_taken_i};
    end
  end

  // second level indexed by the pattern itself
  tbp_ctr_table #(.AW(LH_W)) u_pht (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (lhist_o),
    .rd_ctr_o (rd_ctr),
    .wr_en_i  (upd_en_i),
    .wr_idx_i (upd_hist),
    .wr_up_i  (upd_taken_i)
  );

  assign pred_o = rd_ctr[1];
endmodule

// File: rtl/tbp_global.sv
module tbp_global
  import tbp_pkg::*;
#(
  parameter int GH_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            pred_o,
  output logic [GH_W-1:0] ghist_o,
  input  logic            upd_en_i,
  input  logic            upd_taken_i
);
  logic [GH_W-1:0] ghist_q;
  ctr_t            rd_ctr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ghist_q <= '0;
    else if (upd_en_i) ghist_q <= {ghist_q[GH_W-2:0], upd_taken_i};
  end

  // read and train at the same history: no speculative advance
  tbp_ctr_table #(.AW(GH_W)) u_ght (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (ghist_q),
    .rd_ctr_o (rd_ctr),
    .wr_en_i  (upd_en_i),
    .wr_idx_i (ghist_q),
    .wr_up_i  (upd_taken_i)
  );

  assign pred_o  = rd_ctr[1];
  assign ghist_o = ghist_q;
endmodule

// File: rtl/tbp_top.sv
module tbp_top
  import tbp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int LHT_AW = 10,
  parameter int LH_W   = 10,
  parameter int GH_W   = 12,
  parameter int CH_AW  = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  output logic            pred_local_o,
  output logic            pred_global_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic            upd_local_i,
  input  logic            upd_global_i
);
  logic [LHT_AW-1:0] lht_pidx, lht_uidx;
  logic [CH_AW-1:0]  ch_pidx, ch_uidx;
  logic [LH_W-1:0]   lh_rd;
  logic [GH_W-1:0]   gh_q;
  ctr_t              ch_rd;
  logic              ch_wr, ch_up;
  logic              unused_pc;

  assign lht_pidx  = pred_pc_i[PC_LSB +: LHT_AW];
  assign lht_uidx  = upd_pc_i[PC_LSB +: LHT_AW];
  assign ch_pidx   = pred_pc_i[PC_LSB +: CH_AW];
  assign ch_uidx   = upd_pc_i[PC_LSB +: CH_AW];
  assign unused_pc = ^{pred_pc_i, upd_pc_i};

  tbp_local #(.LHT_AW(LHT_AW), .LH_W(LH_W)) u_local (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pred_idx_i  (lht_pidx),
    .pred_o      (pred_local_o),
    .lhist_o     (lh_rd),
    .upd_en_i    (upd_valid_i),
    .upd_idx_i   (lht_uidx),
    .upd_taken_i (upd_taken_i)
  );

  tbp_global #(.GH_W(GH_W)) u_global (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pred_o      (pred_global_o),
    .ghist_o     (gh_q),
    .upd_en_i    (upd_valid_i),
    .upd_taken_i (upd_taken_i)
  );

  // chooser trains only on disagreement; up means global was right
  assign ch_wr = upd_valid_i & (upd_local_i ^ upd_global_i);
  assign ch_up = ~(upd_global_i ^ upd_taken_i);

  tbp_ctr_table #(.AW(CH_AW)) u_chooser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (ch_pidx),
    .rd_ctr_o (ch_rd),
    .wr_en_i  (ch_wr),
    .wr_idx_i (ch_uidx),
    .wr_up_i  (ch_up)
  );

  assign pred_taken_o = ch_rd[1] ? pred_global_o : pred_local_o;
endmodule

// File: rtl/tbp_chk.sv
module tbp_chk #(
  parameter int PC_W = 32,
  parameter int LH_W = 10,
  parameter int GH_W = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] pred_pc_i,
  input logic            upd_valid_i,
  input logic [PC_W-1:0] upd_pc_i,
  input logic            upd_taken_i,
  input logic            upd_local_i,
  input logic            upd_global_i,
  input logic [LH_W-1:0] lh_rd,
  input logic [GH_W-1:0] gh_q,
  input logic [1:0]      ch_rd
);
  assert_ghist_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> gh_q == {$past(gh_q[GH_W-2:0]), $past(upd_taken_i)});

  assert_lhist_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_pc_i == pred_pc_i) |=>
      (pred_pc_i != $past(pred_pc_i)) || (lh_rd == {$past(lh_rd[LH_W-2:0]), $past(upd_taken_i)}));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(gh_q));

  assert_chooser_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_local_i == upd_global_i) |=>
      (pred_pc_i != $past(pred_pc_i)) || $stable(ch_rd));

  assert_chooser_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_pc_i == pred_pc_i && upd_local_i != upd_global_i &&
     upd_global_i == upd_taken_i && ch_rd == 2'd3) |=>
      (pred_pc_i != $past(pred_pc_i)) || (ch_rd == 2'd3));

  assert_chooser_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_pc_i == pred_pc_i && upd_local_i != upd_global_i &&
     upd_local_i == upd_taken_i && ch_rd == 2'd0) |=>
      (pred_pc_i != $past(pred_pc_i)) || (ch_rd == 2'd0));
endmodule

bind tbp_top tbp_chk #(.PC_W(PC_W), .LH_W(LH_W), .GH_W(GH_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pred_pc_i    (pred_pc_i),
  .upd_valid_i  (upd_valid_i),
  .upd_pc_i     (upd_pc_i),
  .upd_taken_i  (upd_taken_i),
  .upd_local_i  (upd_local_i),
  .upd_global_i (upd_global_i),
  .lh_rd        (lh_rd),
  .gh_q         (gh_q),
  .ch_rd        (ch_rd)
);

// File: tb/sim_tbp_top.sv
module sim_tbp_top;
  localparam int CLK_P  = 10;
  localparam int PC_W   = 6;
  localparam int PC_LSB = 1;
  localparam int LHT_AW = 2;
  localparam int LH_W   = 3;
  localparam int GH_W   = 4;
  localparam int CH_AW  = 3;
  localparam int NPC    = 1 << PC_W;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic            rst_ni;
  logic [PC_W-1:0] pred_pc;
  logic            pred_taken, pred_local, pred_global;
  logic            upd_valid, upd_taken, upd_local, upd_global;
  logic [PC_W-1:0] upd_pc;

  tbp_top #(.PC_W(PC_W), .PC_LSB(PC_LSB), .LHT_AW(LHT_AW), .LH_W(LH_W),
            .GH_W(GH_W), .CH_AW(CH_AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pred_pc_i(pred_pc),
    .pred_taken_o(pred_taken), .pred_local_o(pred_local), .pred_global_o(pred_global),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken),
    .upd_local_i(upd_local), .upd_global_i(upd_global)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // arithmetic model of the tables
  int m_lht  [1 << LHT_AW];
  int m_lctr [1 << LH_W];
  int m_gctr [1 << GH_W];
  int m_ch   [1 << CH_AW];
  int m_gh;

  function automatic int sat(int c, bit up);
    if (up) return (c >= 3) ? 3 : c + 1;
    return (c <= 0) ? 0 : c - 1;
  endfunction

  function automatic int lidx(int pc); return (pc >> PC_LSB) % (1 << LHT_AW); endfunction
  function automatic int cidx(int pc); return (pc >> PC_LSB) % (1 << CH_AW); endfunction
  function automatic bit m_local(int pc); return m_lctr[m_lht[lidx(pc)]] >= 2; endfunction
  function automatic bit m_global(); return m_gctr[m_gh] >= 2; endfunction
  function automatic bit m_final(int pc);
    return (m_ch[cidx(pc)] >= 2) ? m_global() : m_local(pc);
  endfunction

  task automatic m_reset();
    foreach (m_lht[i])  m_lht[i]  = 0;
    foreach (m_lctr[i]) m_lctr[i] = 1;
    foreach (m_gctr[i]) m_gctr[i] = 1;
    foreach (m_ch[i])   m_ch[i]   = 1;
    m_gh = 0;
  endtask

  task automatic m_update(int pc, bit tk, bit pl, bit pg);
    int h;
    h = m_lht[lidx(pc)];
    m_lctr[h]  = sat(m_lctr[h], tk);
    m_gctr[m_gh] = sat(m_gctr[m_gh], tk);
    if (pl != pg) m_ch[cidx(pc)] = sat(m_ch[cidx(pc)], pg == tk);
    m_lht[lidx(pc)] = ((h << 1) | tk) % (1 << LH_W);
    m_gh = ((m_gh << 1) | tk) % (1 << GH_W);
  endtask

  task automatic cmp(bit act, bit exp, string req, string ctx, int pc);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) pc=%0d actual=%0b expected=%0b", req, ctx, pc, act, exp);
    end
  endtask

  task automatic sweep(string ctx);
    for (int pc = 0; pc < NPC; pc++) begin
      pred_pc = pc[PC_W-1:0];
      #1;
      cmp(pred_local,  m_local(pc),  "R2", ctx, pc);
      cmp(pred_global, m_global(),   "R3", ctx, pc);
      cmp(pred_taken,  m_final(pc),  "R4", ctx, pc);
    end
  endtask

  task automatic upd_raw(int pc, bit tk, bit pl, bit pg);
    @(negedge clk);
    pred_pc    = pc[PC_W-1:0];
    upd_pc     = pc[PC_W-1:0];
    upd_taken  = tk;
    upd_local  = pl;
    upd_global = pg;
    upd_valid  = 1'b1;
    @(posedge clk);
    #1 upd_valid = 1'b0;
    m_update(pc, tk, pl, pg);
  endtask

  task automatic upd_model(int pc, bit tk);
    upd_raw(pc, tk, m_local(pc), m_global());
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 190000);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    rst_ni = 1'b0; pred_pc = '0; upd_pc = '0;
    upd_valid = 1'b0; upd_taken = 1'b0; upd_local = 1'b0; upd_global = 1'b0;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1: all outputs not-taken after reset
    sweep("R1 reset");
    for (int pc = 0; pc < NPC; pc++) begin
      pred_pc = pc[PC_W-1:0];
      #1 cmp(pred_taken | pred_local | pred_global, 1'b0, "R1", "reset zero", pc);
    end

    // R6/R8: repeated taken training of one branch
    for (int k = 0; k < 6; k++) begin
      upd_model(2, 1'b1);
      sweep("R6/R8 repeated taken");
    end

    // R5/R7: chooser ramp to top, past saturation, then one step down
    for (int k = 0; k < 4; k++) upd_raw(4, 1'b1, 1'b0, 1'b1);
    sweep("R5 chooser top");
    upd_raw(4, 1'b0, 1'b0, 1'b1);
    sweep("R5 one step below top");
    for (int k = 0; k < 5; k++) upd_raw(4, 1'b0, 1'b0, 1'b1);
    upd_raw(4, 1'b1, 1'b0, 1'b1);
    sweep("R5 chooser floor then up");

    // R7: all eight combinations of outcome and supplied predictions
    for (int c = 0; c < 8; c++) begin
      upd_raw(6 + 2 * (c % 3), c[0], c[1], c[2]);
      sweep("R7 combo");
    end

    // R9: update fields wiggle without the strobe
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      upd_pc = k[PC_W-1:0] * 6'd11; upd_taken = k[0];
      upd_local = k[1]; upd_global = ~k[0];
    end
    @(negedge clk);
    sweep("R9 no strobe");

    // R2/R3/R4/R6/R8: pseudo-random training with model predictions
    lfsr = 16'hACE1;
    for (int k = 0; k < 1500; k++) begin
      int  pc;
      bit  tk;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pc = int'(lfsr[5:0]);
      tk = lfsr[2] ? (lfsr[8] | lfsr[9]) : (lfsr[8] & lfsr[9] & lfsr[11]);
      @(negedge clk);
      pred_pc = pc[PC_W-1:0];
      #1 cmp(pred_taken, m_final(pc), "R4", "pre-update", pc);
      upd_model(pc, tk);
      if (k % 25 == 0) sweep("R6/R8 random");
    end
    sweep("R6/R8 final");

    finish_run();
  end
endmodule